// File: doc/BRIEF.md
# Three-Wire Serial Word-Memory Command Slave

This block is the slave side of a three-wire serial memory with 16-bit words. A host raises a chip select, toggles a serial clock and presents one data bit per serial clock rise; the block shifts the command frame in, decodes it, and either streams words back on its serial output, updates its internal register-array memory, or changes its write-protection state. Word updates are not applied at once. A command that changes memory becomes armed only after its last frame bit, and it is carried out when chip select drops. The block then stays busy for a fixed number of system clock cycles.

All three host pins are sampled with the system clock, and the block acts on the serial clock's rising edges that it detects. The frame length, and so the point after which a write can no longer be withdrawn, follows from the address width parameter (6, 8 or 10 bits). The serial lines are paced entirely by the host. There is no valid/ready handshake and no back-pressure: the host must not read or send faster than the edge detector can sample, and it must not start a new command while the block is busy. It can poll the busy state instead.

Top module: `mw_eeprom_slave`

## Requirements
- R1: A frame starts with the first serial clock rise that sees data-in at 1 while chip select is high; earlier 0 bits are ignored. After the start bit come a 2-bit opcode (MSB first), then ADDR_W address bits (MSB first), then 16 data bits (MSB first) for word write and write-all. The opcodes are: 2'b10 read, 2'b01 write, 2'b11 erase, 2'b00 extended. An extended command is picked by the two address MSBs: 00 disable, 01 write-all, 10 erase-all, 11 enable.
- R2: The output is updated in the system clock cycle that detects a serial clock rise. For a read, the rise that takes the last address bit drives a dummy 0. Each later rise drives the next data bit, MSB first. After 16 bits the next word follows with no gap, at the address plus one, wrapping at the top of the array.
- R3: Dropping chip select aborts a read at any point and changes nothing. The output is 0 while chip select is low and no busy poll is in progress.
- R4: A word write takes effect only if chip select falls after serial clock rise 19+ADDR_W (25, 27 or 29). If chip select falls before that rise, the memory is unchanged and no busy period starts.
- R5: Extra serial clock rises after the final data bit, with chip select still high, do not cancel a write. It still takes effect when chip select falls.
- R6: Erase sets the addressed word to 16'hFFFF and erase-all sets every word to 16'hFFFF. Either takes effect when chip select falls at or after rise 3+ADDR_W.
- R7: Write-all stores the same 16-bit word in every location during one busy period.
- R8: Writing is disabled after reset. The enable command turns it on and the disable command turns it off. While disabled, write, erase, write-all and erase-all leave the memory unchanged and start no busy period.
- R9: Each memory update starts a busy period of BUSY_CYC system clock cycles. A chip select window opened during a busy period is a status poll. It ignores all serial clocks, drives 0 while busy and 1 once ready, and lasts until chip select falls.
- R10: Reset clears every word to 0, drives the output to 0 and leaves the block idle and not busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, high during a frame or a status poll |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| dout | output | 1 | Serial read data, or ready/busy during a status poll |

## Verification
The assertions assume that cs, sk and di are synchronous to clk, that each level is held for at least one clk cycle, and that cs does not change in the same cycle as an sk rise. Under these assumptions every detected sk rise is a real edge, and a commit can only line up with a chip-select fall. The bench drives all three pins on the falling clock edge. It leaves two idle cycles around each sk level and moves cs only while sk is low, so every stimulus stays inside these assumptions.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    EX_LOCK   = 2'b00,
    EX_FILL   = 2'b01,
    EX_WIPE   = 2'b10,
    EX_UNLOCK = 2'b11
  } ext_e;

  typedef enum logic [1:0] {
    ACT_WORD_WR,
    ACT_WORD_ERASE,
    ACT_ALL_WR,
    ACT_ALL_ERASE
  } act_e;
endpackage

// File: rtl/mw_pin_edge.sv
module mw_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  output logic sk_rise,
  output logic cs_rise,
  output logic cs_fall
);
  logic sk_q;
  logic cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sk_q <= 1'b0;
      cs_q <= 1'b0;
    end else begin
      sk_q <= sk;
      cs_q <= cs;
    end
  end

  assign sk_rise = sk & ~sk_q & cs;
  assign cs_rise = cs & ~cs_q;
  assign cs_fall = ~cs & cs_q;
endmodule

// File: rtl/mw_busy.sv
module mw_busy #(
  parameter int BUSY_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cs,
  input  logic cs_rise,
  output logic busy,
  output logic status_win
);
  localparam int BW = $clog2(BUSY_CYC + 1);
  localparam logic [BW-1:0] LOAD = BW'(BUSY_CYC);

  logic [BW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (start) begin
      remain <= LOAD;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_win <= 1'b0;
    end else if (!cs) begin
      status_win <= 1'b0;
    end else if (cs_rise) begin
      status_win <= busy;
    end
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/mw_mem.sv
module mw_mem
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  act_e              act,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      unique case (act)
        ACT_WORD_WR:    cells[waddr] <= wdata;
        ACT_WORD_ERASE: cells[waddr] <= '1;
        ACT_ALL_WR:     for (int i = 0; i < DEPTH; i++) cells[i] <= wdata;
        ACT_ALL_ERASE:  for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        default:        ;
      endcase
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/mw_frame.sv
module mw_frame
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              di,
  input  logic              sk_rise,
  input  logic              mute,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              do_bit,
  output logic              armed,
  output logic              wr_en,
  output act_e              act,
  output logic [ADDR_W-1:0] act_addr,
  output logic [WORD_W-1:0] act_data
);
  localparam int ADDR_LAST  = 3 + ADDR_W;
  localparam int FRAME_LAST = ADDR_LAST + WORD_W;
  localparam int CNT_W      = $clog2(FRAME_LAST + 1);
  localparam int BIT_W      = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] C_OP_END    = CNT_W'(3);
  localparam logic [CNT_W-1:0] C_ADDR_END  = CNT_W'(ADDR_LAST);
  localparam logic [CNT_W-1:0] C_FRAME_END = CNT_W'(FRAME_LAST);
  localparam logic [BIT_W-1:0] C_WORD_DONE = BIT_W'(WORD_W);

  logic              started;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_nx;
  logic [1:0]        op_sr;
  logic [ADDR_W-1:0] addr_sr;
  logic [ADDR_W-1:0] addr_full;
  logic [WORD_W-1:0] data_sr;
  logic [WORD_W-1:0] data_full;
  logic              rd_on;
  logic [BIT_W-1:0]  rd_cnt;
  logic [WORD_W-1:0] rd_sh;
  logic [ADDR_W-1:0] rd_ptr;
  logic              at_addr_end;
  logic              at_frame_end;
  op_e               op;
  ext_e              top_now;
  ext_e              top_held;

  assign cnt_nx       = (cnt == C_FRAME_END) ? cnt : cnt + 1'b1;
  assign at_addr_end  = started && (cnt_nx == C_ADDR_END) && (cnt != C_ADDR_END);
  assign at_frame_end = started && (cnt_nx == C_FRAME_END) && (cnt != C_FRAME_END);
  assign addr_full    = {addr_sr[ADDR_W-2:0], di};
  assign data_full    = {data_sr[WORD_W-2:0], di};
  assign op           = op_e'(op_sr);
  assign top_now      = ext_e'(addr_full[ADDR_W-1 -: 2]);
  assign top_held     = ext_e'(addr_sr[ADDR_W-1 -: 2]);
  assign mem_raddr    = at_addr_end ? addr_full : ADDR_W'(rd_ptr + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started  <= 1'b0;
      cnt      <= '0;
      op_sr    <= '0;
      addr_sr  <= '0;
      data_sr  <= '0;
      rd_on    <= 1'b0;
      rd_cnt   <= '0;
      rd_sh    <= '0;
      rd_ptr   <= '0;
      do_bit   <= 1'b0;
      armed    <= 1'b0;
      wr_en    <= 1'b0;
      act      <= ACT_WORD_WR;
      act_addr <= '0;
      act_data <= '0;
    end else if (!cs) begin
      started <= 1'b0;
      cnt     <= '0;
      rd_on   <= 1'b0;
      do_bit  <= 1'b0;
      armed   <= 1'b0;
    end else if (sk_rise && !mute) begin
      if (!started) begin
        if (di) begin
          started <= 1'b1;
          cnt     <= CNT_W'(1);
        end
      end else begin
        cnt <= cnt_nx;
        if (cnt_nx <= C_OP_END)           op_sr   <= {op_sr[0], di};
        else if (cnt_nx <= C_ADDR_END)    addr_sr <= addr_full;
        else if (cnt_nx <= C_FRAME_END)   data_sr <= data_full;

        if (at_addr_end) begin
          unique case (op)
            OP_READ: begin
              rd_on  <= 1'b1;
              rd_ptr <= addr_full;
              rd_sh  <= mem_rdata;
              rd_cnt <= '0;
              do_bit <= 1'b0;
            end
            OP_ERASE: begin
              act_addr <= addr_full;
              act      <= ACT_WORD_ERASE;
              armed    <= wr_en;
            end
            OP_WRITE: act_addr <= addr_full;
            OP_EXT: begin
              unique case (top_now)
                EX_UNLOCK: wr_en <= 1'b1;
                EX_LOCK:   wr_en <= 1'b0;
                EX_WIPE: begin
                  act   <= ACT_ALL_ERASE;
                  armed <= wr_en;
                end
                default: ;
              endcase
            end
            default: ;
          endcase
        end

        if (at_frame_end && wr_en) begin
          if (op == OP_WRITE) begin
            act      <= ACT_WORD_WR;
            act_data <= data_full;
            armed    <= 1'b1;
          end else if (op == OP_EXT && top_held == EX_FILL) begin
            act      <= ACT_ALL_WR;
            act_data <= data_full;
            armed    <= 1'b1;
          end
        end

        if (rd_on) begin
          if (rd_cnt == C_WORD_DONE) begin
            rd_ptr <= mem_raddr;
            do_bit <= mem_rdata[WORD_W-1];
            rd_sh  <= {mem_rdata[WORD_W-2:0], 1'b0};
            rd_cnt <= BIT_W'(1);
          end else begin
            do_bit <= rd_sh[WORD_W-1];
            rd_sh  <= {rd_sh[WORD_W-2:0], 1'b0};
            rd_cnt <= rd_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int BUSY_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout
);
  logic              sk_rise;
  logic              cs_rise;
  logic              cs_fall;
  logic              busy;
  logic              status_win;
  logic              armed;
  logic              wr_en;
  logic              mem_we;
  logic              do_bit;
  act_e              act;
  logic [ADDR_W-1:0] act_addr;
  logic [ADDR_W-1:0] mem_raddr;
  logic [WORD_W-1:0] act_data;
  logic [WORD_W-1:0] mem_rdata;

  mw_pin_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk),
    .sk_rise(sk_rise), .cs_rise(cs_rise), .cs_fall(cs_fall)
  );

  mw_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs(cs), .di(di), .sk_rise(sk_rise),
    .mute(status_win), .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
    .do_bit(do_bit), .armed(armed), .wr_en(wr_en), .act(act),
    .act_addr(act_addr), .act_data(act_data)
  );

  assign mem_we = cs_fall & armed & ~busy;

  mw_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(mem_we), .cs(cs), .cs_rise(cs_rise),
    .busy(busy), .status_win(status_win)
  );

  mw_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .act(act), .waddr(act_addr),
    .wdata(act_data), .raddr(mem_raddr), .rdata(mem_rdata)
  );

  assign dout = status_win ? ~busy : do_bit;
endmodule

// File: rtl/mw_checker.sv
module mw_checker (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic dout,
  input logic mem_we,
  input logic wr_en,
  input logic busy,
  input logic status_win
);
  AST_DOUT_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && !$past(cs)) |-> !dout); // R3

  AST_WRITE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wr_en); // R8

  AST_COMMIT_ON_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $fell(cs)); // R4

  AST_COMMIT_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> busy); // R9

  AST_POLL_SHOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_win && busy) |-> !dout); // R9

  AST_POLL_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    status_win |=> !mem_we); // R9
endmodule

bind mw_eeprom_slave mw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .dout(dout), .mem_we(mem_we),
  .wr_en(wr_en), .busy(busy), .status_win(status_win)
);

// File: tb/test_mw_eeprom_slave.sv
module test_mw_eeprom_slave;
  localparam int A     = 6;
  localparam int DEPTH = 1 << A;
  localparam int BUSY  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic sk = 1'b0;
  logic di = 1'b0;
  logic dout;

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R10";
  bit    done = 1'b0;

  always #2 clk = ~clk;

  mw_eeprom_slave #(.ADDR_W(A), .BUSY_CYC(BUSY)) i_mw_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .dout(dout)
  );

  // ---------------- behavioural reference ----------------
  int  m_mem [DEPTH];
  bit  m_en, m_win, m_started, m_armed, m_rd, m_do, m_csq, m_skq, m_exp;
  int  m_busy, m_op, m_top, m_addr, m_raddr, m_kind, m_waddr, m_wdata;
  bit  q [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_en = 0; m_win = 0; m_started = 0; m_armed = 0; m_rd = 0; m_do = 0;
      m_csq = 0; m_skq = 0; m_busy = 0; q.delete(); m_exp = 0;
    end else begin
      bit busy_pre, fire;
      busy_pre = (m_busy > 0);
      fire = m_csq && !cs && m_armed;
      if (m_busy > 0) m_busy--;
      if (fire) begin
        case (m_kind)
          0: m_mem[m_waddr] = m_wdata;
          1: m_mem[m_waddr] = 16'hFFFF;
          2: foreach (m_mem[i]) m_mem[i] = m_wdata;
          default: foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
        endcase
        m_busy = BUSY;
      end
      if (cs && !m_csq) m_win = busy_pre;
      if (!cs) begin
        m_win = 0; m_started = 0; q.delete(); m_armed = 0; m_rd = 0; m_do = 0;
      end else if (sk && !m_skq && !m_win) begin
        if (!m_started) begin
          if (di) m_started = 1;
        end else begin
          int n;
          q.push_back(di);
          n = q.size();
          if (n == 2 + A) begin
            m_op = q[0] * 2 + q[1];
            m_top = q[2] * 2 + q[3];
            m_addr = 0;
            for (int i = 0; i < A; i++) m_addr = m_addr * 2 + q[2 + i];
            case (m_op)
              2: begin m_rd = 1; m_raddr = m_addr; m_do = 0; end
              3: if (m_en) begin m_armed = 1; m_kind = 1; m_waddr = m_addr; end
              0: begin
                if (m_top == 3) m_en = 1;
                else if (m_top == 0) m_en = 0;
                else if (m_top == 2 && m_en) begin m_armed = 1; m_kind = 3; end
              end
              default: ;
            endcase
          end
          if (m_rd && n > 2 + A) begin
            int k, w;
            k = n - 3 - A;
            w = (m_raddr + k / 16) % DEPTH;
            m_do = (m_mem[w] >> (15 - k % 16)) & 1;
          end
          if (n == 18 + A && m_en && (m_op == 1 || (m_op == 0 && m_top == 1))) begin
            m_wdata = 0;
            for (int i = 0; i < 16; i++) m_wdata = m_wdata * 2 + q[2 + A + i];
            m_armed = 1;
            m_kind = (m_op == 1) ? 0 : 2;
            m_waddr = m_addr;
          end
        end
      end
      m_exp = m_win ? (m_busy == 0) : m_do;
      m_csq = cs; m_skq = sk;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (dout !== m_exp) begin
        n_err++;
        $display("FAIL %s model: dout=%0b expected %0b at %0t", cur_req, dout, m_exp, $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit b, output bit s);
    di = b;
    tick(1);
    sk = 1'b1;
    tick(1);
    s = dout;
    sk = 1'b0;
    tick(1);
  endtask

  task automatic send(input int val, input int n);
    bit s;
    for (int i = n - 1; i >= 0; i--) pulse(bit'((val >> i) & 1), s);
  endtask

  task automatic open_cs();
    cs = 1'b1;
    tick(1);
  endtask

  task automatic close_cs();
    cs = 1'b0;
    sk = 1'b0;
    di = 1'b0;
    tick(2);
  endtask

  task automatic wait_ready(input string req);
    int t = 0;
    open_cs();
    while (dout !== 1'b1 && t < 400) begin tick(1); t++; end
    check(dout === 1'b1 && t > 0, req, t, 1);
    close_cs();
  endtask

  task automatic write_word(input int addr, input int data, input int extra, input bit wait_rdy);
    open_cs();
    send(1, 1); send(1, 2); send(addr, A); send(data, 16);
    if (extra > 0) send(0, extra);
    close_cs();
    if (wait_rdy) wait_ready(cur_req);
  endtask

  task automatic ext_cmd(input int top, input int data, input bit with_data, input bit wait_rdy);
    open_cs();
    send(1, 1); send(0, 2); send(top << (A - 2), A);
    if (with_data) send(data, 16);
    close_cs();
    if (wait_rdy) wait_ready(cur_req);
  endtask

  task automatic read_words(input int addr, input int n, output logic [15:0] w [4]);
    bit s;
    open_cs();
    send(1, 1); send(2, 2); send(addr >> 1, A - 1);
    pulse(bit'(addr & 1), s);
    check(s == 1'b0, "R2 dummy bit", s, 0);
    for (int j = 0; j < n; j++) begin
      w[j] = '0;
      for (int b = 0; b < 16; b++) begin
        pulse(1'b0, s);
        w[j] = {w[j][14:0], s};
      end
    end
    close_cs();
  endtask

  task automatic expect_word(input int addr, input int exp, input string req);
    logic [15:0] w [4];
    read_words(addr, 1, w);
    check(w[0] == 16'(exp), req, w[0], exp);
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] w [4];
    tick(4);
    rst_n = 1'b1;
    tick(1);
    cur_req = "R10";
    check(dout == 1'b0, "R10 reset dout", dout, 0);
    expect_word(0, 16'h0000, "R10 reset contents");

    cur_req = "R8";
    write_word(5, 16'hA5C3, 0, 1'b0);
    tick(3);
    expect_word(5, 16'h0000, "R8 write while disabled");

    ext_cmd(3, 0, 1'b0, 1'b0);
    cur_req = "R4";
    write_word(5, 16'hA5C3, 0, 1'b1);
    expect_word(5, 16'hA5C3, "R4 committed write");

    open_cs();
    send(1, 1); send(1, 2); send(6, A); send(16'h7E7E >> 1, 15);
    close_cs();
    tick(3);
    expect_word(6, 16'h0000, "R4 abort before last data rise");

    cur_req = "R5";
    write_word(7, 16'h3C96, 5, 1'b1);
    expect_word(7, 16'h3C96, "R5 extra clocks");

    cur_req = "R2";
    read_words(5, 3, w);
    check(w[0] == 16'hA5C3, "R2 stream word0", w[0], 16'hA5C3);
    check(w[1] == 16'h0000, "R2 stream word1", w[1], 16'h0000);
    check(w[2] == 16'h3C96, "R2 stream word2", w[2], 16'h3C96);

    cur_req = "R3";
    open_cs();
    send(1, 1); send(2, 2); send(7, A); send(0, 8);
    close_cs();
    expect_word(7, 16'h3C96, "R3 aborted read");

    cur_req = "R9";
    write_word(9, 16'h1111, 0, 1'b0);
    open_cs();
    check(dout == 1'b0, "R9 poll busy", dout, 0);
    send(1, 1); send(1, 2); send(10, A); send(16'h2222, 16);
    while (dout !== 1'b1) tick(1);
    close_cs();
    expect_word(10, 16'h0000, "R9 command in poll ignored");
    expect_word(9, 16'h1111, "R9 write before poll");

    cur_req = "R1";
    open_cs();
    send(0, 3); send(1, 1); send(1, 2); send(11, A); send(16'h0F0F, 16);
    close_cs();
    wait_ready("R1");
    expect_word(11, 16'h0F0F, "R1 leading zeros");

    cur_req = "R6";
    open_cs();
    send(1, 1); send(3, 2); send(5, A);
    close_cs();
    wait_ready("R6");
    expect_word(5, 16'hFFFF, "R6 word erase");

    cur_req = "R2";
    write_word(63, 16'hBEEF, 0, 1'b1);
    read_words(63, 2, w);
    check(w[0] == 16'hBEEF, "R2 top word", w[0], 16'hBEEF);
    check(w[1] == 16'h0000, "R2 wrap to 0", w[1], 16'h0000);

    cur_req = "R7";
    ext_cmd(1, 16'h1234, 1'b1, 1'b1);
    expect_word(0, 16'h1234, "R7 fill addr 0");
    expect_word(33, 16'h1234, "R7 fill addr 33");
    expect_word(63, 16'h1234, "R7 fill addr 63");

    cur_req = "R6";
    ext_cmd(2, 0, 1'b0, 1'b1);
    expect_word(20, 16'hFFFF, "R6 erase all");

    cur_req = "R8";
    ext_cmd(0, 0, 1'b0, 1'b0);
    write_word(3, 16'h5555, 0, 1'b0);
    tick(3);
    expect_word(3, 16'hFFFF, "R8 write after disable");

    tick(4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule